// File: doc/BRIEF.md
# Scaled FP32 to 8-bit Float Converter

This block turns a stream of single-precision words into 8-bit floating-point bytes. Before encoding, each word is multiplied by a power of two held in the block. A format select picks one of two byte layouts. Layout 0 has a sign bit, a 4-bit exponent with bias 7 and a 3-bit fraction. Layout 1 has a sign bit, a 5-bit exponent with bias 15 and a 2-bit fraction. The multiply is done by adding to the exponent, so the block has no multiplier. Rounding is round-to-nearest-even. Results beyond the largest finite code saturate to that code.

The block also finds its own scale. A start strobe opens a tensor, and a three-state controller with states IDLE, COLLECT and UPDATE then tracks the largest magnitude among the words it accepts. An end strobe closes the tensor. In the UPDATE cycle the controller computes a new scale exponent that places that largest magnitude just below the top of the selected layout's range. The new scale applies to the words that follow.

The controller has three transitions:
- IDLE to COLLECT on the start strobe.
- COLLECT to UPDATE on the end strobe.
- UPDATE back to IDLE unconditionally after one cycle.

Top module: `fp8_scale_conv`

## Requirements
- R1: A word accepted (in_valid and in_ready both high at a rising edge) appears as out_data, with out_valid high, after that edge. out_valid is low after any edge with no acceptance. With fmt_sel=0 a normal result is {sign, exponent+7 (4 bits), fraction (3 bits)}; with fmt_sel=1 it is {sign, exponent+15 (5 bits), fraction (2 bits)}.
- R2: Fraction bits that are dropped round to nearest, with ties going to an even fraction.
- R3: Results above the largest finite value, including FP32 infinity and results that carry out through rounding, give sign plus 0x7E for layout 0 (448) or sign plus 0x7B for layout 1 (57344).
- R4: Results below the smallest normal value are encoded as subnormals, with exponent field 0 and value fraction × 2^-9 (layout 0) or fraction × 2^-16 (layout 1). Results that round below the smallest subnormal give signed zero.
- R5: An FP32 NaN gives sign plus 0x7F (layout 0) or sign plus 0x7E (layout 1). An FP32 zero or subnormal gives zero with the input's sign.
- R6: Each word is multiplied by 2^scale_exp before encoding. scale_exp is a two's-complement 8-bit value.
- R7: The start strobe in IDLE moves to COLLECT, and the end strobe in COLLECT moves to UPDATE. UPDATE lasts one cycle, during which in_ready is low; in_ready is high in every other state.
- R8: The tracked maximum is cleared by the start strobe. It covers the magnitudes of words accepted in COLLECT, including a word accepted in the end-strobe cycle. Words accepted in IDLE do not count, and neither do NaN or infinite words.
- R9: In UPDATE, the maximum's unbiased exponent e gives a new scale of emax-1-e. emax is 8 for layout 0 and 15 for layout 1. An FP32 subnormal maximum uses e=-126. A zero maximum gives 0. The result is clamped to 127. The new scale is visible on scale_exp from the cycle after UPDATE.
- R10: scale_exp is 0 after reset and changes only at the end of an UPDATE cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 32 | FP32 input word |
| fmt_sel | input | 1 | 0: 4/3 layout, 1: 5/2 layout |
| tensor_start | input | 1 | Opens a tensor for statistics |
| tensor_end | input | 1 | Closes the tensor and triggers a scale update |
| out_valid | output | 1 | out_data holds a converted byte |
| out_data | output | 8 | Converted 8-bit float |
| scale_exp | output | 8 | Current power-of-two scale exponent, signed |

## Verification
A converted byte is due one edge after its word is accepted. in_ready drops for exactly the one cycle that follows the edge that samples the end strobe. The new scale_exp appears one edge later still, two edges after the end strobe. The bench drives every input on a falling edge and reads outputs on the next falling edge, so each check samples exactly the cycle these latencies name.

// File: rtl/fp8_pkg.sv
package fp8_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_UPDATE  = 2'd2
    } trk_state_e;

    localparam int F32_BIAS = 127;
    localparam int F32_MIN_E = -126;

    // Unbiased exponent of the largest finite value per layout
    function automatic int fmt_emax(input logic fmt);
        return fmt ? 15 : 8;
    endfunction

endpackage

// File: rtl/fp8_encode.sv
module fp8_encode #(
    parameter int EXP_W        = 4,
    parameter int MAN_W        = 3,
    parameter bit IEEE_SPECIAL = 1'b0,
    parameter int SCALE_W      = 8
) (
    input  logic [31:0]              word,
    input  logic signed [SCALE_W-1:0] scale,
    output logic [7:0]               code
);
    localparam int MAG_W     = EXP_W + MAN_W;
    localparam int BIAS      = 2**(EXP_W-1) - 1;
    localparam int MAX_FIELD = IEEE_SPECIAL ? 2**EXP_W - 2 : 2**EXP_W - 1;
    localparam int MAX_MAN   = IEEE_SPECIAL ? 2**MAN_W - 1 : 2**MAN_W - 2;
    localparam int MAX_CODE  = MAX_FIELD * 2**MAN_W + MAX_MAN;
    localparam int NAN_CODE  = IEEE_SPECIAL ? (2**EXP_W - 1) * 2**MAN_W + 2**(MAN_W-1)
                                            : 2**MAG_W - 1;
    localparam int SH_BASE   = 23 - MAN_W;
    localparam int SH_MAX    = 25;

    logic [7:0]       ex;
    logic [22:0]      mn;
    logic [47:0]      ext;
    logic [23:0]      kept;
    logic             rnd, sticky, inc;
    logic [MAG_W-1:0] mag;
    int               be_i, sh_i, mag_i;

    always_comb begin
        ex   = word[30:23];
        mn   = word[22:0];
        be_i = int'(ex) - fp8_pkg::F32_BIAS + int'(scale) + BIAS;
        sh_i = SH_BASE + ((be_i < 1) ? (1 - be_i) : 0);
        if (sh_i > SH_MAX) sh_i = SH_MAX;
        ext    = {1'b1, mn, 24'b0} >> sh_i;
        kept   = ext[47:24];
        rnd    = ext[23];
        sticky = |ext[22:0];
        inc    = rnd & (sticky | kept[0]);
        // rounding carry ripples into the exponent field naturally
        mag_i  = ((be_i >= 1) ? (be_i * 2**MAN_W + int'(kept[MAN_W-1:0])) : int'(kept))
                 + int'(inc);
        if (ex == 8'hFF && mn != 23'd0) mag = MAG_W'(NAN_CODE);
        else if (ex == 8'hFF)           mag = MAG_W'(MAX_CODE);
        else if (ex == 8'h00)           mag = '0;
        else if (mag_i > MAX_CODE)      mag = MAG_W'(MAX_CODE);
        else                            mag = MAG_W'(mag_i);
        code = {word[31], mag};
    end

endmodule

// File: rtl/fp8_amax_scale.sv
module fp8_amax_scale #(
    parameter int SCALE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc,
    input  logic [30:0]              mag_in,
    input  logic                     fmt_sel,
    input  logic                     tensor_start,
    input  logic                     tensor_end,
    output logic                     in_ready,
    output logic signed [SCALE_W-1:0] scale_exp
);
    import fp8_pkg::*;

    localparam int S_HI = 2**(SCALE_W-1) - 1;
    localparam int S_LO = -(2**(SCALE_W-1));

    trk_state_e  state_q, state_d;
    logic [30:0] amax_q;
    int          e_i, s_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tensor_start) state_d = ST_COLLECT;
            ST_COLLECT: if (tensor_end)   state_d = ST_UPDATE;
            ST_UPDATE:                    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready = (state_q != ST_UPDATE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amax_q <= '0;
        end else if (state_q == ST_IDLE && tensor_start) begin
            amax_q <= '0;
        end else if (state_q == ST_COLLECT && acc && mag_in[30:23] != 8'hFF
                     && mag_in > amax_q) begin
            amax_q <= mag_in;
        end
    end

    always_comb begin
        e_i = ((amax_q[30:23] == 8'd0) ? 1 : int'(amax_q[30:23])) - F32_BIAS;
        s_i = fmt_emax(fmt_sel) - 1 - e_i;
        if (s_i > S_HI) s_i = S_HI;
        if (s_i < S_LO) s_i = S_LO;
        if (amax_q == 31'd0) s_i = 0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   scale_exp <= '0;
        else if (state_q == ST_UPDATE) scale_exp <= SCALE_W'(s_i);
    end

    p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && tensor_end) |=> !in_ready);

    p_scale_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_UPDATE) |=> $stable(scale_exp));

    p_amax_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT) |=> (amax_q >= $past(amax_q)));

endmodule

// File: rtl/fp8_scale_conv.sv
module fp8_scale_conv #(
    parameter int SCALE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [31:0]              in_data,
    input  logic                     fmt_sel,
    input  logic                     tensor_start,
    input  logic                     tensor_end,
    output logic                     out_valid,
    output logic [7:0]               out_data,
    output logic signed [SCALE_W-1:0] scale_exp
);
    localparam int N_FMT = 2;

    logic       acc;
    logic [7:0] codes [N_FMT];

    assign acc = in_valid & in_ready;

    fp8_amax_scale #(.SCALE_W(SCALE_W)) trk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc          (acc),
        .mag_in       (in_data[30:0]),
        .fmt_sel      (fmt_sel),
        .tensor_start (tensor_start),
        .tensor_end   (tensor_end),
        .in_ready     (in_ready),
        .scale_exp    (scale_exp)
    );

    for (genvar f = 0; f < N_FMT; f++) begin : g_fmt
        fp8_encode #(
            .EXP_W        (f == 0 ? 4 : 5),
            .MAN_W        (f == 0 ? 3 : 2),
            .IEEE_SPECIAL (f != 0),
            .SCALE_W      (SCALE_W)
        ) enc_i (
            .word  (in_data),
            .scale (scale_exp),
            .code  (codes[f])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= acc;
            if (acc) out_data <= codes[fmt_sel];
        end
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !out_valid);

    p_no_nan_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !fmt_sel && in_data[30:23] != 8'hFF) |=> (out_data[6:0] != 7'h7F));

endmodule

// File: tb/fp8_scale_conv_tb.sv
module fp8_scale_conv_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        fmt_sel = 1'b0;
    logic        tensor_start = 1'b0;
    logic        tensor_end = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic signed [7:0] scale_exp;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp8_scale_conv dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .fmt_sel(fmt_sel), .tensor_start(tensor_start),
        .tensor_end(tensor_end), .out_valid(out_valid), .out_data(out_data),
        .scale_exp(scale_exp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic conv(input string req, input logic fmt, input logic [31:0] w,
                        input logic [7:0] exp);
        @(negedge clk);
        fmt_sel = fmt; in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, {24'd0, out_data}, {24'd0, exp});
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic open_tensor(input logic fmt);
        @(negedge clk);
        fmt_sel = fmt; tensor_start = 1'b1;
        @(negedge clk);
        tensor_start = 1'b0;
    endtask

    task automatic close_tensor(input string req, input logic [7:0] exp_scale);
        @(negedge clk);
        tensor_end = 1'b1;
        @(negedge clk);
        tensor_end = 1'b0;
        check("R7 ready low in update", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        check("R7 ready back", {31'd0, in_ready}, 32'd1);
        check(req, {24'd0, scale_exp}, {24'd0, exp_scale});
    endtask

    task automatic t_reset();
        check("R10 reset scale", {24'd0, scale_exp}, 32'd0);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R7 reset ready", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        check("R1 no accept no valid", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_normals();
        conv("R1 e4m3 1.0", 1'b0, 32'h3F800000, 8'h38);
        conv("R1 e4m3 -2.0", 1'b0, 32'hC0000000, 8'hC0);
        conv("R1 e5m2 1.0", 1'b1, 32'h3F800000, 8'h3C);
        @(negedge clk);
        check("R1 valid drops", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_rounding();
        conv("R2 tie to even down", 1'b0, 32'h3F880000, 8'h38);
        conv("R2 tie to even up", 1'b0, 32'h3F980000, 8'h3A);
    endtask

    task automatic t_saturate();
        conv("R3 e4m3 1000", 1'b0, 32'h447A0000, 8'h7E);
        conv("R3 e4m3 round carry 480", 1'b0, 32'h43F00000, 8'h7E);
        conv("R3 e5m2 1e5", 1'b1, 32'h47C35000, 8'h7B);
        conv("R3 e4m3 -inf", 1'b0, 32'hFF800000, 8'hFE);
    endtask

    task automatic t_subnormal();
        conv("R4 e4m3 min sub", 1'b0, 32'h3B000000, 8'h01);
        conv("R4 e4m3 sub 3", 1'b0, 32'h3BC00000, 8'h03);
        conv("R4 e4m3 half min tie", 1'b0, 32'h3A800000, 8'h00);
        conv("R4 e4m3 1.5 half min", 1'b0, 32'h3AC00000, 8'h01);
        conv("R4 e4m3 underflow", 1'b0, 32'hBA000000, 8'h80);
        conv("R4 e5m2 min sub", 1'b1, 32'h37800000, 8'h01);
    endtask

    task automatic t_specials();
        conv("R5 e4m3 nan", 1'b0, 32'h7FC00000, 8'h7F);
        conv("R5 e5m2 -nan", 1'b1, 32'hFFC00000, 8'hFE);
        conv("R5 -zero", 1'b0, 32'h80000000, 8'h80);
        conv("R5 +zero", 1'b1, 32'h00000000, 8'h00);
        conv("R5 fp32 subnormal flush", 1'b0, 32'h80000005, 8'h80);
    endtask

    task automatic t_scale_e4m3();
        open_tensor(1'b0);
        push(32'hC0400000);
        push(32'h3F000000);
        close_tensor("R9 e4m3 scale from -3.0", 8'd6);
        conv("R6 1.0 scaled by 64", 1'b0, 32'h3F800000, 8'h68);
        conv("R6 -3.0 scaled by 64", 1'b0, 32'hC0400000, 8'hF4);
    endtask

    task automatic t_idle_ignored();
        push(32'h447A0000);
        open_tensor(1'b0);
        push(32'h3F800000);
        close_tensor("R8 idle word ignored", 8'd7);
    endtask

    task automatic t_nan_ignored();
        open_tensor(1'b0);
        push(32'h7FC00000);
        push(32'h7F800000);
        push(32'h3F800000);
        close_tensor("R8 nan inf ignored", 8'd7);
    endtask

    task automatic t_end_cycle_word();
        open_tensor(1'b0);
        push(32'h3F800000);
        @(negedge clk);
        tensor_end = 1'b1; in_valid = 1'b1; in_data = 32'h41000000;
        @(negedge clk);
        tensor_end = 1'b0; in_valid = 1'b0;
        check("R7 ready low after end", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        check("R8 end-cycle word counted", {24'd0, scale_exp}, 32'd4);
    endtask

    task automatic t_scale_e5m2();
        open_tensor(1'b1);
        push(32'h47C35000);
        close_tensor("R9 e5m2 negative scale", 8'hFE);
        conv("R6 e5m2 1.0 times 0.25", 1'b1, 32'h3F800000, 8'h34);
    endtask

    task automatic t_zero_tensor();
        open_tensor(1'b0);
        push(32'h00000000);
        push(32'h80000000);
        close_tensor("R9 zero max gives 0", 8'd0);
    endtask

    task automatic t_clamp();
        open_tensor(1'b0);
        push(32'h00000001);
        close_tensor("R9 clamp to 127", 8'd127);
        repeat (3) @(negedge clk);
        check("R10 scale held", {24'd0, scale_exp}, 32'd127);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normals();
        t_rounding();
        t_saturate();
        t_subnormal();
        t_specials();
        t_scale_e4m3();
        t_idle_ignored();
        t_nan_ignored();
        t_end_cycle_word();
        t_scale_e5m2();
        t_zero_tensor();
        t_clamp();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule